// File: doc/BRIEF.md
# Page write load controller

This block sits behind the host write port of a byte-wide nonvolatile memory. It watches active-low chip-select, output-enable and write-enable strobes together with a 16-bit address and an 8-bit data bus. Every qualified write pulse loads one byte into a page buffer. The buffer keeps one data byte and one valid flag per in-page offset. All bytes of a load share a single page number, taken from the upper address bits.

The load stays open for as long as the host keeps issuing write pulses within a byte-load window. When the window expires with no new byte, the block enters a self-timed programming phase. In that phase it walks the page buffer and writes every valid byte to the memory array through a simple write port. It holds `busy` high for a fixed number of cycles.

The strobes pass through a two-flop synchronizer before edge detection. Every timing value is a parameter counted in clock cycles: the window, the programming time and the minimum strobe width. `PROG_CYC` must be larger than the page size plus one.

Top module: `page_load_ctrl`

## Requirements
- R1: A write is recognised only while `cs_n` and `we_n` are both low and `oe_n` is high. A pulse taken with `oe_n` low loads nothing and starts no programming.
- R2: The byte's address is the address present when the later of the two enables (`cs_n`, `we_n`) falls. Its data is the data present just before the earlier of the two rises.
- R3: A write pulse that is active for fewer than `MIN_PULSE` synchronized cycles is discarded. It loads nothing and does not restart the window.
- R4: The page number is address bits 15..7, and the offset is bits 6..0. A byte whose page differs from the first byte of the open load is discarded. It also sets `page_err`, which stays high until reset.
- R5: Programming starts (`busy` rises) exactly `WIN_CYC`+3 clock edges after the edge that follows the release of the last accepted pulse. A new pulse released no more than `WIN_CYC` cycles after the previous release keeps the load open, so total load time has no limit.
- R6: During programming, each valid buffer byte is written exactly once to `arr_addr` = {page, offset}, in ascending offset order. When an offset was loaded twice, the last value is written. All writes occur while `busy` is high.
- R7: `busy` stays high for exactly `PROG_CYC` cycles. Write pulses that begin while it is high are ignored.
- R8: During and right after reset, `busy`, `page_err` and `arr_we` are low.
- R9: A single load accepts every one of the 128 offsets and commits all of them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| oe_n | input | 1 | Output enable, active low; low inhibits writes |
| we_n | input | 1 | Write enable, active low |
| addr | input | 16 | Host byte address |
| din | input | 8 | Host write data |
| busy | output | 1 | Programming in progress |
| page_err | output | 1 | Sticky flag: a byte for a foreign page was dropped |
| arr_we | output | 1 | Array write strobe, one cycle per byte |
| arr_addr | output | 16 | Array write address |
| arr_wdata | output | 8 | Array write data |

## Verification
The assertions assume the host keeps `addr` and `din` steady while a strobe is active. They also assume the host never lets a pulse race the window expiry. The ordering and page checks on `arr_we` only hold if each committed page came from one buffer fill. The stimulus drives every bus change on the falling clock edge. It places each follow-on pulse no later than the window boundary, which it also hits exactly. Pulses meant to be ignored land well inside the `busy` interval.

// File: rtl/page_load_pkg.sv
package page_load_pkg;
  typedef enum logic [1:0] {
    LD_IDLE = 2'd0,
    LD_FILL = 2'd1,
    LD_PROG = 2'd2
  } ld_state_t;
endpackage

// File: rtl/strobe_sync.sv
// Delays strobes and buses through the same flop chain so they stay aligned.
module strobe_sync #(
  parameter int AW     = 16,
  parameter int DW     = 8,
  parameter int STAGES = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          cs_s,
  output logic          oe_s,
  output logic          we_s,
  output logic [AW-1:0] addr_s,
  output logic [DW-1:0] din_s
);
  localparam int BW = 3 + AW + DW;
  localparam logic [BW-1:0] REST = {3'b111, {(AW + DW){1'b0}}};

  logic [BW-1:0] pipe [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= REST;
        else     pipe[g] <= {cs_n, oe_n, we_n, addr, din};
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst) pipe[g] <= REST;
        else     pipe[g] <= pipe[g-1];
      end
    end
  end

  assign {cs_s, oe_s, we_s, addr_s, din_s} = pipe[STAGES-1];
endmodule

// File: rtl/strobe_qual.sv
// Turns a synchronized write pulse into one load event with address and data.
module strobe_qual #(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int MIN_PULSE = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_s,
  input  logic          oe_s,
  input  logic          we_s,
  input  logic [AW-1:0] addr_s,
  input  logic [DW-1:0] din_s,
  input  logic          block,
  output logic          load_vld,
  output logic [AW-1:0] load_addr,
  output logic [DW-1:0] load_data
);
  localparam int CW = $clog2(MIN_PULSE + 1);

  logic          act, act_q, armed;
  logic [CW-1:0] wcnt;
  logic [AW-1:0] a_lat;
  logic [DW-1:0] d_hold;

  assign act = ~cs_s & ~we_s & oe_s;

  always_ff @(posedge clk) begin
    if (rst) begin
      act_q     <= 1'b0;
      armed     <= 1'b0;
      wcnt      <= '0;
      a_lat     <= '0;
      d_hold    <= '0;
      load_vld  <= 1'b0;
      load_addr <= '0;
      load_data <= '0;
    end else begin
      act_q    <= act;
      load_vld <= 1'b0;
      if (act && !act_q) begin
        // both enables now low: the later falling edge fixes the address
        a_lat  <= addr_s;
        d_hold <= din_s;
        wcnt   <= CW'(1);
        armed  <= ~block;
      end else if (act) begin
        d_hold <= din_s;
        if (wcnt != CW'(MIN_PULSE)) wcnt <= wcnt + CW'(1);
      end else if (act_q) begin
        // first rising edge ended the pulse: data held from last active cycle
        load_vld  <= armed & ~block & (wcnt == CW'(MIN_PULSE));
        load_addr <= a_lat;
        load_data <= d_hold;
        armed     <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/page_buffer.sv
// Page data in an inferable RAM, valid flags in flops.
module page_buffer #(
  parameter int PAGE_BITS = 7,
  parameter int DW        = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic [PAGE_BITS-1:0] wr_idx,
  input  logic [DW-1:0]        wr_data,
  input  logic                 rd_en,
  input  logic [PAGE_BITS-1:0] rd_idx,
  input  logic                 clr,
  output logic [DW-1:0]        rd_data,
  output logic                 rd_vld
);
  localparam int DEPTH = 1 << PAGE_BITS;

  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] vmask;

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_idx] <= wr_data;
    if (rd_en) rd_data <= mem[rd_idx];
  end

  always_ff @(posedge clk) begin
    if (rst || clr) vmask <= '0;
    else if (wr_en) vmask[wr_idx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) rd_vld <= 1'b0;
    else     rd_vld <= rd_en & vmask[rd_idx];
  end
endmodule

// File: rtl/page_load_ctrl.sv
module page_load_ctrl
  import page_load_pkg::*;
#(
  parameter int AW        = 16,
  parameter int DW        = 8,
  parameter int PAGE_BITS = 7,
  parameter int WIN_CYC   = 40,
  parameter int PROG_CYC  = 200,
  parameter int MIN_PULSE = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cs_n,
  input  logic          oe_n,
  input  logic          we_n,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] din,
  output logic          busy,
  output logic          page_err,
  output logic          arr_we,
  output logic [AW-1:0] arr_addr,
  output logic [DW-1:0] arr_wdata
);
  localparam int PAGE = 1 << PAGE_BITS;
  localparam int PGW  = AW - PAGE_BITS;
  localparam int WCW  = $clog2(WIN_CYC);
  localparam int PCW  = $clog2(PROG_CYC);

  logic          cs_s, oe_s, we_s;
  logic [AW-1:0] addr_s;
  logic [DW-1:0] din_s;
  logic          load_vld;
  logic [AW-1:0] load_addr;
  logic [DW-1:0] load_data;

  ld_state_t      state;
  logic [WCW-1:0] win_cnt;
  logic [PCW-1:0] prog_cnt;
  logic [PGW-1:0] page_q;
  logic           busy_q, err_q;
  logic [AW-1:0]  arr_addr_q;

  logic match, buf_we, timeout, scan, prog_last;

  strobe_sync #(.AW(AW), .DW(DW), .STAGES(2)) u_sync (
    .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .cs_s(cs_s), .oe_s(oe_s), .we_s(we_s),
    .addr_s(addr_s), .din_s(din_s)
  );

  strobe_qual #(.AW(AW), .DW(DW), .MIN_PULSE(MIN_PULSE)) u_qual (
    .clk(clk), .rst(rst), .cs_s(cs_s), .oe_s(oe_s), .we_s(we_s),
    .addr_s(addr_s), .din_s(din_s), .block(busy_q),
    .load_vld(load_vld), .load_addr(load_addr), .load_data(load_data)
  );

  always_comb begin
    match     = (load_addr[AW-1:PAGE_BITS] == page_q);
    buf_we    = load_vld & ((state == LD_IDLE) | ((state == LD_FILL) & match));
    timeout   = (state == LD_FILL) & (win_cnt == WCW'(WIN_CYC - 1)) & ~buf_we;
    scan      = (state == LD_PROG) & (prog_cnt < PCW'(PAGE));
    prog_last = (state == LD_PROG) & (prog_cnt == PCW'(PROG_CYC - 1));
  end

  page_buffer #(.PAGE_BITS(PAGE_BITS), .DW(DW)) u_buf (
    .clk(clk), .rst(rst),
    .wr_en(buf_we), .wr_idx(load_addr[PAGE_BITS-1:0]), .wr_data(load_data),
    .rd_en(scan), .rd_idx(prog_cnt[PAGE_BITS-1:0]), .clr(prog_last),
    .rd_data(arr_wdata), .rd_vld(arr_we)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= LD_IDLE;
      win_cnt    <= '0;
      prog_cnt   <= '0;
      page_q     <= '0;
      busy_q     <= 1'b0;
      err_q      <= 1'b0;
      arr_addr_q <= '0;
    end else begin
      arr_addr_q <= {page_q, prog_cnt[PAGE_BITS-1:0]};
      case (state)
        LD_IDLE: begin
          if (load_vld) begin
            page_q  <= load_addr[AW-1:PAGE_BITS];
            win_cnt <= '0;
            state   <= LD_FILL;
          end
        end
        LD_FILL: begin
          if (load_vld && !match) err_q <= 1'b1;
          if (buf_we) begin
            win_cnt <= '0;
          end else if (timeout) begin
            state    <= LD_PROG;
            prog_cnt <= '0;
            busy_q   <= 1'b1;
          end else begin
            win_cnt <= win_cnt + WCW'(1);
          end
        end
        LD_PROG: begin
          prog_cnt <= prog_cnt + PCW'(1);
          if (prog_last) begin
            state  <= LD_IDLE;
            busy_q <= 1'b0;
          end
        end
        default: state <= LD_IDLE;
      endcase
    end
  end

  assign busy     = busy_q;
  assign page_err = err_q;
  assign arr_addr = arr_addr_q;
endmodule

// File: rtl/page_load_chk.sv
module page_load_chk #(
  parameter int AW        = 16,
  parameter int PAGE_BITS = 7,
  parameter int PROG_CYC  = 200
) (
  input logic          clk,
  input logic          rst,
  input logic          busy,
  input logic          page_err,
  input logic          arr_we,
  input logic [AW-1:0] arr_addr
);
  int                       bcnt;
  logic                     seen;
  logic [PAGE_BITS-1:0]     last_off;
  logic [AW-PAGE_BITS-1:0]  last_pg;

  always_ff @(posedge clk) begin
    if (rst || !busy) bcnt <= 0;
    else              bcnt <= bcnt + 1;
  end

  always_ff @(posedge clk) begin
    if (rst || !busy) begin
      seen     <= 1'b0;
      last_off <= '0;
      last_pg  <= '0;
    end else if (arr_we) begin
      seen     <= 1'b1;
      last_off <= arr_addr[PAGE_BITS-1:0];
      last_pg  <= arr_addr[AW-1:PAGE_BITS];
    end
  end

  p_reset_quiet_r8: assert property (@(posedge clk)
    $fell(rst) |-> (!busy && !arr_we && !page_err));

  p_write_in_busy_r6: assert property (@(posedge clk) disable iff (rst)
    arr_we |-> busy);

  p_ascending_r6: assert property (@(posedge clk) disable iff (rst)
    (arr_we && seen) |-> (arr_addr[PAGE_BITS-1:0] > last_off));

  p_one_page_r4: assert property (@(posedge clk) disable iff (rst)
    (arr_we && seen) |-> (arr_addr[AW-1:PAGE_BITS] == last_pg));

  p_err_sticky_r4: assert property (@(posedge clk) disable iff (rst)
    page_err |=> page_err);

  p_busy_len_r7: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (bcnt == PROG_CYC));

  p_busy_max_r7: assert property (@(posedge clk) disable iff (rst)
    busy |-> (bcnt < PROG_CYC));
endmodule

bind page_load_ctrl page_load_chk #(
  .AW(AW), .PAGE_BITS(PAGE_BITS), .PROG_CYC(PROG_CYC)
) u_chk (
  .clk(clk), .rst(rst), .busy(busy), .page_err(page_err),
  .arr_we(arr_we), .arr_addr(arr_addr)
);

// File: tb/sim_page_load_ctrl.sv
module sim_page_load_ctrl;
  localparam int W    = 40;
  localparam int P    = 200;
  localparam int MINP = 3;

  logic        clk = 1'b0, rst = 1'b1;
  logic        cs_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
  logic [15:0] addr = '0;
  logic [7:0]  din = '0;
  logic        busy, page_err, arr_we;
  logic [15:0] arr_addr;
  logic [7:0]  arr_wdata;

  page_load_ctrl #(.WIN_CYC(W), .PROG_CYC(P), .MIN_PULSE(MINP)) u0 (
    .clk(clk), .rst(rst), .cs_n(cs_n), .oe_n(oe_n), .we_n(we_n),
    .addr(addr), .din(din), .busy(busy), .page_err(page_err),
    .arr_we(arr_we), .arr_addr(arr_addr), .arr_wdata(arr_wdata)
  );

  always #4 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int vectors = 0, miscomp = 0;
  int b_start = -1, b_end = -1, err_cyc = 1 << 30;
  bit pend = 0, done = 0;
  int mpage;
  int mdat [128];
  bit mval [128];
  logic [23:0] expq [$];
  string tag = "R8";

  function automatic bit exp_busy(int n);
    return (b_start >= 0) && (n >= b_start) && (n < b_end);
  endfunction

  task automatic check(string t, string what, int got, int exp);
    vectors++;
    if (got != exp) begin
      miscomp++;
      $display("FAIL %s %s got %0h exp %0h (cycle %0d)", t, what, got, exp, cyc);
    end
  endtask

  // reference model: update at page close, compare every clock
  always @(negedge clk) begin
    if (!done) begin
      if (pend && cyc >= b_start) begin
        for (int k = 0; k < 128; k++) begin
          if (mval[k]) expq.push_back({9'(mpage), 7'(k), 8'(mdat[k])});
          mval[k] = 0;
        end
        pend = 0;
      end
      check(tag, "busy", busy, exp_busy(cyc));
      check(tag, "page_err", page_err, cyc >= err_cyc);
      if (arr_we) begin
        if (expq.size() == 0) begin
          check(tag, "unexpected arr_we", 1, 0);
        end else begin
          logic [23:0] it;
          it = expq.pop_front();
          check(tag, "arr_addr", arr_addr, it[23:8]);
          check(tag, "arr_wdata", arr_wdata, it[7:0]);
        end
      end
    end
  end

  task automatic note_load(int a, int d, int width, int t0, int m);
    if (width < MINP || exp_busy(t0) || exp_busy(m)) return;
    if (!pend) begin
      pend = 1;
      mpage = a >> 7;
    end else if ((a >> 7) != mpage) begin
      if (err_cyc > m + 4) err_cyc = m + 4;
      return;
    end
    mdat[a & 127] = d;
    mval[a & 127] = 1;
    b_start = m + W + 4;
    b_end = b_start + P;
  endtask

  task automatic wr(int a, int d, int width, int gap);
    int t0, m;
    @(negedge clk);
    addr = 16'(a); din = 8'(d); oe_n = 1'b1; cs_n = 1'b0; we_n = 1'b0;
    t0 = cyc;
    repeat (width) @(negedge clk);
    cs_n = 1'b1; we_n = 1'b1;
    m = cyc;
    note_load(a, d, width, t0, m);
    repeat (gap) @(negedge clk);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (pend || cyc < b_end + 2) @(negedge clk);
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000 && !done) begin
      done = 1;
      miscomp++;
      $display("FAIL R7 watchdog expired got %0d exp %0d", cyc, 150000);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
      $finish;
    end
  end

  initial begin
    int t0, m;
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (3) @(negedge clk);

    // R1: single qualified byte
    tag = "R1";
    wr(16'h0905, 8'h3C, 4, 0);
    wait_idle();

    // R6: several offsets, one rewritten, unsorted order
    tag = "R6";
    wr(16'h1503, 8'h11, 4, 5);
    wr(16'h150A, 8'h22, 5, 5);
    wr(16'h1503, 8'h33, 4, 5);
    wr(16'h157F, 8'h44, 4, 5);
    wr(16'h1500, 8'h55, 6, 5);
    wait_idle();

    // R2: write enable falls first, chip select last; write enable rises first
    tag = "R2";
    @(negedge clk);
    addr = 16'h2211; din = 8'hA5; we_n = 1'b0; cs_n = 1'b1; oe_n = 1'b1;
    @(negedge clk);
    addr = 16'h2244; cs_n = 1'b0; t0 = cyc;
    repeat (4) @(negedge clk);
    we_n = 1'b1; m = cyc;
    note_load(16'h2244, 8'hA5, 4, t0, m);
    @(negedge clk);
    din = 8'h5A;
    @(negedge clk);
    cs_n = 1'b1; addr = 16'h2211;
    wait_idle();

    // R1: output enable low inhibits the write
    tag = "R1";
    @(negedge clk);
    addr = 16'h3001; din = 8'h77; oe_n = 1'b0; cs_n = 1'b0; we_n = 1'b0;
    repeat (5) @(negedge clk);
    cs_n = 1'b1; we_n = 1'b1;
    @(negedge clk);
    oe_n = 1'b1;
    repeat (W + 20) @(negedge clk);

    // R3: too-short pulse rejected, full-width pulse accepted
    tag = "R3";
    wr(16'h4010, 8'h99, MINP - 1, 10);
    repeat (W + 20) @(negedge clk);
    wr(16'h4012, 8'h98, MINP, 0);
    wait_idle();

    // R4: foreign page dropped, error stays set
    tag = "R4";
    wr(16'h5001, 8'h01, 4, 3);
    wr(16'h5081, 8'hEE, 4, 3);
    wr(16'h5002, 8'h02, 4, 3);
    wait_idle();

    // R7: pulse issued while busy is ignored
    tag = "R7";
    wr(16'h6020, 8'h61, 4, 0);
    @(negedge clk);
    while (!(exp_busy(cyc) && cyc >= b_start + 5)) @(negedge clk);
    wr(16'h6021, 8'h62, 4, 0);
    wait_idle();

    // R9: every offset of one page
    tag = "R9";
    for (int k = 0; k < 128; k++) wr(16'h7000 + k, (k ^ 8'h5A) & 8'hFF, 4, 1);
    wait_idle();

    // R5: long load with gaps up to exactly the window limit
    tag = "R5";
    for (int k = 0; k < 8; k++) wr(16'h0100 + 3 * k, 8'h80 + k, 4, 30);
    for (int k = 0; k < 4; k++) wr(16'h0140 + k, 8'hC0 + k, 4, W - 5);
    wait_idle();

    tag = "R6";
    check(tag, "pending array writes", expq.size(), 0);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscomp);
    $finish;
  end
endmodule